// File: doc/BRIEF.md
# Sector Lock Command Sequencer

This block sits on the write path of a banked non-volatile memory and holds one protection bit per sector. It watches bus write cycles for a three-write handshake. Two opening writes of data 60h name a bank. After them the block stays in a lock-edit mode, and every further 60h write to a sector of that bank sets or clears that sector's bit, chosen by address bit 6. A write of F0h ends the mode. While the mode is open, read requests aimed at the chosen bank are flagged as blocked.

Program and erase logic uses the registered write-permission output for the sector it addresses. An active-low write-protect pin forces the two outermost boot sectors to read as locked whatever their stored bits hold. The stored bits themselves are left as they are, so the forced state lasts only while the pin is low.

Bank count and sectors per bank are parameters. Sectors are numbered globally, and the bank of a sector is its index divided by the sectors per bank. With the default bottom-boot setting, the boot sectors are indices 0 and 1.

Top module: `sector_lock_seq`

## Requirements
- R1: Reset sets every stored lock bit to 1. It drives lock_vec to all ones and drives rd_blocked and wr_allow to 0, and the sequencer starts idle.
- R2: In idle, a 60h write arms the sequencer and records the bank of wr_sector. A second 60h write whose sector lies in that same bank opens the lock-edit mode.
- R3: From idle, a write whose data is not 60h keeps the sequencer idle. While armed, a write with data other than 60h, or with a sector in another bank, returns it to idle. Neither case changes any lock bit.
- R4: While open, a 60h write to a sector of the selected bank locks that sector when wr_a6 is 0 and unlocks it when wr_a6 is 1. The change shows in lock_vec one cycle after the write.
- R5: The mode stays open after each sector update, so any number of sectors in the selected bank can be changed before it is closed.
- R6: While open, a 60h write to a sector outside the selected bank changes no lock bit.
- R7: A write of F0h returns the sequencer to idle from any state. It clears rd_blocked in the following cycle.
- R8: rd_blocked is 1 one cycle after a cycle in which rd_req is 1, the mode is open and rd_bank equals the selected bank. Otherwise it is 0.
- R9: While wp_n is 0, sectors 0 and 1 show as 1 in lock_vec one cycle later. Their stored bits are kept, and they show again once wp_n returns to 1.
- R10: wr_allow is 1 one cycle after a cycle in which the sector on wr_sector had a stored bit of 0 and was not forced by wp_n. In every other case wr_allow is 0.
- R11: While open, a write whose data is neither 60h nor F0h is ignored. The mode stays open and no bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_sector | input | SW (5) | Global sector index of the write or permission query |
| wr_a6 | input | 1 | Address bit 6: 0 = lock, 1 = unlock |
| wr_data | input | 8 | Write data (command code) |
| wp_n | input | 1 | Write-protect pin, active low |
| rd_req | input | 1 | Read request |
| rd_bank | input | BW (2) | Bank addressed by the read request |
| lock_vec | output | NSECT (32) | Effective lock state per sector |
| wr_allow | output | 1 | Program/erase permission for wr_sector |
| rd_blocked | output | 1 | Read of rd_bank refused |

## Verification
Each of the three outputs is registered once. The effect of a write on lock_vec, of a read request on rd_blocked, and of a wr_sector value on wr_allow is therefore due at the first rising edge after the stimulus cycle. wr_allow and rd_blocked use the state as it stood before that edge. The bench drives inputs on falling edges. It advances a behavioural reference model at every rising edge and compares all three outputs at the next falling edge, so each expected value is matched to the edge at which the design registers it. The directed checks sample at that same falling edge, one cycle after the write or query that they test.

// File: rtl/sls_pkg.sv
package sls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_OPEN  = 2'd2
  } seq_state_t;

  localparam logic [7:0] CMD_EDIT = 8'h60;
  localparam logic [7:0] CMD_EXIT = 8'hF0;
endpackage

// File: rtl/sls_cmd_fsm.sv
module sls_cmd_fsm
  import sls_pkg::*;
#(
  parameter int BW  = 2,
  parameter int SBW = 3,
  localparam int SW = BW + SBW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sector,
  input  logic          wr_a6,
  input  logic [7:0]    wr_data,
  output logic          mode_open,
  output logic [BW-1:0] sel_bank,
  output logic          upd_en,
  output logic [SW-1:0] upd_idx,
  output logic          upd_val
);
  seq_state_t    st_q, st_d;
  logic [BW-1:0] bank_q, bank_d;
  logic [BW-1:0] wr_bank;
  logic          is_edit, is_exit, same_bank;

  assign wr_bank   = wr_sector[SW-1:SBW];
  assign is_edit   = wr_en && (wr_data == CMD_EDIT);
  assign is_exit   = wr_en && (wr_data == CMD_EXIT);
  assign same_bank = (wr_bank == bank_q);

  always_comb begin
    st_d   = st_q;
    bank_d = bank_q;
    if (is_exit) begin
      st_d = ST_IDLE;
    end else if (wr_en) begin
      unique case (st_q)
        ST_IDLE: if (is_edit) begin
          st_d   = ST_ARMED;
          bank_d = wr_bank;
        end
        ST_ARMED: st_d = (is_edit && same_bank) ? ST_OPEN : ST_IDLE;
        ST_OPEN:  st_d = ST_OPEN;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      bank_q <= '0;
    end else begin
      st_q   <= st_d;
      bank_q <= bank_d;
    end
  end

  assign mode_open = (st_q == ST_OPEN);
  assign sel_bank  = bank_q;
  assign upd_en    = mode_open && is_edit && same_bank;
  assign upd_idx   = wr_sector;
  assign upd_val   = ~wr_a6;

  // R3: a first write that is not 60h keeps the sequencer idle
  a_r3_idle_reject: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && wr_en && wr_data != CMD_EDIT) |=> (st_q == ST_IDLE));

  // R7: the exit command always returns to idle
  a_r7_exit_idle: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == CMD_EXIT) |=> (st_q == ST_IDLE));

  // R5: an open mode keeps its bank until it is closed
  a_r5_open_holds: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OPEN && !(wr_en && wr_data == CMD_EXIT))
      |=> (st_q == ST_OPEN && $stable(bank_q)));
endmodule

// File: rtl/sls_lock_store.sv
module sls_lock_store #(
  parameter int NSECT    = 32,
  parameter bit BOOT_LOW = 1'b1,
  localparam int SW = $clog2(NSECT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [SW-1:0]    upd_idx,
  input  logic             upd_val,
  input  logic             wp_n,
  input  logic [SW-1:0]    wr_sector,
  output logic [NSECT-1:0] lock_vec,
  output logic             wr_allow
);
  logic [NSECT-1:0] bits_q, bits_d;
  logic [NSECT-1:0] boot_mask;
  logic [NSECT-1:0] force_mask;

  for (genvar g = 0; g < NSECT; g++) begin : g_boot
    if (BOOT_LOW) begin : g_low
      assign boot_mask[g] = (g < 2);
    end else begin : g_high
      assign boot_mask[g] = (g >= NSECT - 2);
    end
  end

  assign force_mask = wp_n ? '0 : boot_mask;

  always_comb begin
    bits_d = bits_q;
    if (upd_en) bits_d[upd_idx] = upd_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q   <= '1;
      lock_vec <= '1;
      wr_allow <= 1'b0;
    end else begin
      bits_q   <= bits_d;
      lock_vec <= bits_d | force_mask;
      wr_allow <= ~bits_q[wr_sector] & ~force_mask[wr_sector];
    end
  end

  // R4: an accepted update lands in the stored bit
  a_r4_update_lands: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (bits_q[$past(upd_idx)] == $past(upd_val)));

  // R9: the protect pin forces the boot sectors locked
  a_r9_boot_forced: assert property (@(posedge clk) disable iff (rst)
    !wp_n |=> ((lock_vec & boot_mask) == boot_mask));

  // R10: a locked sector never grants write permission
  a_r10_no_allow_locked: assert property (@(posedge clk) disable iff (rst)
    bits_q[wr_sector] |=> !wr_allow);
endmodule

// File: rtl/sector_lock_seq.sv
module sector_lock_seq #(
  parameter int NUM_BANKS     = 4,
  parameter int SECT_PER_BANK = 8,
  parameter bit BOOT_LOW      = 1'b1,
  localparam int BW    = $clog2(NUM_BANKS),
  localparam int SBW   = $clog2(SECT_PER_BANK),
  localparam int SW    = BW + SBW,
  localparam int NSECT = NUM_BANKS * SECT_PER_BANK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_sector,
  input  logic             wr_a6,
  input  logic [7:0]       wr_data,
  input  logic             wp_n,
  input  logic             rd_req,
  input  logic [BW-1:0]    rd_bank,
  output logic [NSECT-1:0] lock_vec,
  output logic             wr_allow,
  output logic             rd_blocked
);
  logic          mode_open;
  logic [BW-1:0] sel_bank;
  logic          upd_en;
  logic [SW-1:0] upd_idx;
  logic          upd_val;

  sls_cmd_fsm #(.BW(BW), .SBW(SBW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sector (wr_sector),
    .wr_a6     (wr_a6),
    .wr_data   (wr_data),
    .mode_open (mode_open),
    .sel_bank  (sel_bank),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_val   (upd_val)
  );

  sls_lock_store #(.NSECT(NSECT), .BOOT_LOW(BOOT_LOW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_val   (upd_val),
    .wp_n      (wp_n),
    .wr_sector (wr_sector),
    .lock_vec  (lock_vec),
    .wr_allow  (wr_allow)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_blocked <= 1'b0;
    else     rd_blocked <= rd_req && mode_open && (rd_bank == sel_bank);
  end

  // R8: reads are never refused while the mode is closed
  a_r8_no_block_closed: assert property (@(posedge clk) disable iff (rst)
    !mode_open |=> !rd_blocked);
endmodule

// File: tb/sector_lock_seq_tb.sv
`timescale 1ns/1ps
module sector_lock_seq_tb;
  localparam int NB = 4, SPB = 8, NS = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sector = '0;
  logic        wr_a6 = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        wp_n = 1'b1;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_bank = '0;
  logic [NS-1:0] lock_vec;
  logic        wr_allow, rd_blocked;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sector_lock_seq u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sector(wr_sector), .wr_a6(wr_a6),
    .wr_data(wr_data), .wp_n(wp_n), .rd_req(rd_req), .rd_bank(rd_bank),
    .lock_vec(lock_vec), .wr_allow(wr_allow), .rd_blocked(rd_blocked)
  );

  // behavioural reference model: 0 idle, 1 armed, 2 open
  int          m_st = 0;
  int          m_bank = 0;
  logic [NS-1:0] m_lock = '1;
  logic [NS-1:0] e_lv = '1;
  logic        e_wa = 1'b0, e_rb = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_bank = 0; m_lock = '1;
      e_lv = '1; e_wa = 1'b0; e_rb = 1'b0;
    end else begin
      int b;
      bit forced;
      b = int'(wr_sector) / SPB;
      forced = !wp_n && (wr_sector < 2);
      e_wa = !m_lock[wr_sector] && !forced;
      e_rb = rd_req && (m_st == 2) && (int'(rd_bank) == m_bank);
      if (wr_en) begin
        if (wr_data == 8'hF0) m_st = 0;
        else if (m_st == 0) begin
          if (wr_data == 8'h60) begin m_st = 1; m_bank = b; end
        end else if (m_st == 1) begin
          m_st = (wr_data == 8'h60 && b == m_bank) ? 2 : 0;
        end else begin
          if (wr_data == 8'h60 && b == m_bank) m_lock[wr_sector] = !wr_a6;
        end
      end
      e_lv = m_lock;
      if (!wp_n) e_lv[1:0] = 2'b11;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (lock_vec !== e_lv) begin
        failures++;
        $display("FAIL R4 lock_vec actual=%h expected=%h", lock_vec, e_lv);
      end
      checks++;
      if (wr_allow !== e_wa) begin
        failures++;
        $display("FAIL R10 wr_allow actual=%b expected=%b", wr_allow, e_wa);
      end
      checks++;
      if (rd_blocked !== e_rb) begin
        failures++;
        $display("FAIL R8 rd_blocked actual=%b expected=%b", rd_blocked, e_rb);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int sec, input bit a6, input logic [7:0] d);
    wr_sector = sec[4:0]; wr_a6 = a6; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int bank);
    rd_req = 1'b1; rd_bank = bank[1:0];
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(lock_vec == '1 && !rd_blocked && !wr_allow, "R1", lock_vec, 32'hFFFF_FFFF);
    rst = 1'b0;
    tick();

    // R3: bank mismatch on the second cycle
    wr(9, 0, 8'h60); wr(2, 0, 8'h60);
    rd(1);
    chk(!rd_blocked, "R3", rd_blocked, 0);
    // R3: wrong data on the first cycle
    wr(9, 0, 8'h90); wr(9, 0, 8'h60);
    rd(1);
    chk(!rd_blocked, "R3", rd_blocked, 0);
    wr(0, 0, 8'hF0);

    // R2: open bank 1
    wr(9, 0, 8'h60); wr(10, 0, 8'h60);
    rd(1);
    chk(rd_blocked, "R2", rd_blocked, 1);
    rd(0);
    chk(!rd_blocked, "R8", rd_blocked, 0);

    // R4 and R5: unlock and relock inside the bank
    wr(11, 1, 8'h60);
    chk(!lock_vec[11], "R4", lock_vec[11], 0);
    wr(12, 1, 8'h60);
    wr(11, 0, 8'h60);
    chk(lock_vec[11] && !lock_vec[12], "R5", {lock_vec[12], lock_vec[11]}, 2'b01);

    // R6: outside the selected bank
    wr(3, 1, 8'h60);
    chk(lock_vec[3], "R6", lock_vec[3], 1);

    // R11: other data ignored while open
    wr(13, 1, 8'h90);
    chk(lock_vec[13], "R11", lock_vec[13], 1);
    rd(1);
    chk(rd_blocked, "R11", rd_blocked, 1);

    // R10: permission follows the stored bits
    wr_sector = 5'd12; tick();
    chk(wr_allow, "R10", wr_allow, 1);
    wr_sector = 5'd11; tick();
    chk(!wr_allow, "R10", wr_allow, 0);

    // R7: exit clears the read block
    wr(0, 0, 8'hF0);
    rd(1);
    chk(!rd_blocked, "R7", rd_blocked, 0);

    // R9: boot sectors under write-protect
    wr(1, 0, 8'h60); wr(1, 0, 8'h60);
    wr(0, 1, 8'h60); wr(1, 1, 8'h60);
    chk(lock_vec[1:0] == 2'b00, "R9", lock_vec[1:0], 0);
    wp_n = 1'b0; wr_sector = 5'd0; tick();
    chk(lock_vec[1:0] == 2'b11, "R9", lock_vec[1:0], 3);
    tick();
    chk(!wr_allow, "R10", wr_allow, 0);
    wp_n = 1'b1; tick();
    chk(lock_vec[1:0] == 2'b00, "R9", lock_vec[1:0], 0);
    wr(0, 0, 8'hF0);

    // R7: exit from the armed state
    wr(5, 0, 8'h60); wr(5, 0, 8'hF0); wr(5, 0, 8'h60);
    rd(0);
    chk(!rd_blocked, "R7", rd_blocked, 0);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      wr_en = ($urandom_range(0, 2) != 0);
      wr_sector = 5'($urandom_range(0, NS - 1));
      wr_a6 = 1'($urandom_range(0, 1));
      wr_data = (r < 6) ? 8'h60 : (r < 8) ? 8'hF0 : 8'($urandom_range(0, 255));
      if ($urandom_range(0, 15) == 0) wp_n = ~wp_n;
      rd_req = 1'($urandom_range(0, 1));
      rd_bank = 2'($urandom_range(0, NB - 1));
      tick();
    end
    wr_en = 1'b0; rd_req = 1'b0;
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule